// File: doc/BRIEF.md
# Packed Word Insert Unit

This execution unit writes one 16-bit word into a packed vector at a lane chosen by an 8-bit immediate. All other lanes keep the value of a base vector. The caller decodes the instruction and supplies the operand values and control fields. The unit returns a registered result one cycle after it accepts a request. With the result it gives a destination write-enable or an invalid-opcode indication.

There are three forms. The narrow form has a 64-bit destination and four lanes. The in-place wide form has a 128-bit destination and eight lanes. Both of these take their base from the destination's current value. The three-operand wide form takes its base from a separate source vector and writes a distinct destination.

The forms differ above bit 127 of the 256-bit architectural register. The narrow form and the in-place wide form keep those bits, while the three-operand form clears them. The three-operand form also checks its encoding fields and traps the illegal combinations. The unit has no status-flag outputs, so it changes no flags.

Top module: `word_insert_unit`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `res_valid` is high in the following cycle only. After reset, `req_ready` is high, and `res_valid`, `wr_en` and `ud_exc` are low.
- R2: Only bits [15:0] of `scalar_src` are inserted. Bits [31:16] have no effect on the result.
- R3: With `form` = 2'b00 (narrow), `imm[1:0]` selects lane n, which is bits [16n+15:16n], and `imm[7:2]` is ignored. Result bits [255:64] equal `dst_cur[255:64]`.
- R4: With `form` = 2'b01 or 2'b10 (wide), `imm[2:0]` selects one of eight lanes, and `imm[7:3]` is ignored.
- R5: Every lane other than the selected one equals the same lane of the base vector.
- R6: For forms 2'b00 and 2'b01 the base vector is `dst_cur`. For form 2'b10 the base vector is `base_src`.
- R7: With form 2'b01, result bits [255:128] equal `dst_cur[255:128]`.
- R8: With form 2'b10 and no exception, result bits [255:128] are zero.
- R9: Form 2'b10 with `len_bit` = 1 raises the invalid-opcode exception.
- R10: Form 2'b10 with `w_bit` = 1 raises the exception when `long_mode` = 0. When `long_mode` = 1, `w_bit` is ignored. Forms 2'b00 and 2'b01 ignore both `len_bit` and `w_bit`.
- R11: Form code 2'b11 is reserved and also raises the exception. On an exception, `ud_exc` is high with `res_valid` for one cycle, `wr_en` stays low, and `res_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| form | input | 2 | 00 narrow, 01 wide in-place, 10 wide three-operand, 11 reserved |
| imm | input | 8 | Lane-select immediate |
| scalar_src | input | 32 | Scalar source; low word is inserted |
| dst_cur | input | 256 | Current destination register value |
| base_src | input | 128 | First source vector for the three-operand form |
| len_bit | input | 1 | Vector-length encoding bit |
| w_bit | input | 1 | W encoding bit |
| long_mode | input | 1 | Processor is in 64-bit mode |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 256 | New destination value |
| wr_en | output | 1 | Destination write-enable |
| ud_exc | output | 1 | Invalid-opcode exception |

## Verification
The upper-half assertions compare `res_data` with the `form` and `dst_cur` seen one cycle earlier. They therefore assume the operand inputs are meaningful in the cycle a request is accepted. The stimulus drives every operand field together with `req_valid` and holds them through the accepting edge. The assertions also assume that `form` and the encoding bits are driven to known values whenever `req_valid` is high, and the stimulus never leaves them undriven. Back-to-back requests present new operands in each accepting cycle, so every result pairs with exactly one request.

// File: rtl/wi_pkg.sv
package wi_pkg;
   typedef enum logic [1:0] {
      FORM_NARROW       = 2'b00,
      FORM_WIDE_INPLACE = 2'b01,
      FORM_WIDE_3OP     = 2'b10,
      FORM_RSVD         = 2'b11
   } wi_form_e;
endpackage

// File: rtl/wi_lane_merge.sv
module wi_lane_merge #(
   parameter int WORD_W = 16,
   parameter int LANES  = 8,
   localparam int SEL_W = $clog2(LANES),
   localparam int VEC_W = WORD_W * LANES
) (
   input  logic [VEC_W-1:0]  base_vec,
   input  logic [WORD_W-1:0] ins_word,
   input  logic [SEL_W-1:0]  lane_sel,
   output logic [VEC_W-1:0]  merged
);
   generate
      if (LANES < 2 || (1 << SEL_W) != LANES) begin : g_bad_lanes
         $error("wi_lane_merge: LANES must be a power of two of at least 2");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign merged[g*WORD_W +: WORD_W] =
            (lane_sel == SEL_W'(g)) ? ins_word : base_vec[g*WORD_W +: WORD_W];
      end
   endgenerate
endmodule

// File: rtl/wi_ud_check.sv
module wi_ud_check
   import wi_pkg::*;
(
   input  wi_form_e form,
   input  logic     len_bit,
   input  logic     w_bit,
   input  logic     long_mode,
   output logic     ud
);
   always_comb begin
      unique case (form)
         FORM_WIDE_3OP: ud = len_bit | (w_bit & ~long_mode);
         FORM_RSVD:     ud = 1'b1;
         default:       ud = 1'b0;
      endcase
   end
endmodule

// File: rtl/wi_result_build.sv
module wi_result_build
   import wi_pkg::*;
#(
   parameter int REG_W        = 256,
   parameter int WORD_W       = 16,
   parameter int NARROW_LANES = 4,
   parameter int WIDE_LANES   = 8,
   parameter int IMM_W        = 8,
   parameter int SCALAR_W     = 32,
   localparam int NARROW_W = WORD_W * NARROW_LANES,
   localparam int WIDE_W   = WORD_W * WIDE_LANES,
   localparam int NSEL_W   = $clog2(NARROW_LANES),
   localparam int WSEL_W   = $clog2(WIDE_LANES)
) (
   input  wi_form_e            form,
   input  logic [IMM_W-1:0]    imm,
   input  logic [SCALAR_W-1:0] scalar_src,
   input  logic [REG_W-1:0]    dst_cur,
   input  logic [WIDE_W-1:0]   base_src,
   input  logic                ud,
   output logic [REG_W-1:0]    next_data
);
   logic [WORD_W-1:0]   ins_word;
   logic [NARROW_W-1:0] narrow_res;
   logic [WIDE_W-1:0]   wide_base;
   logic [WIDE_W-1:0]   wide_res;
   logic                unused_hi;

   assign ins_word  = scalar_src[WORD_W-1:0];
   assign unused_hi = ^{scalar_src[SCALAR_W-1:WORD_W], imm[IMM_W-1:WSEL_W]};
   assign wide_base = (form == FORM_WIDE_3OP) ? base_src : dst_cur[WIDE_W-1:0];

   generate
      if (SCALAR_W <= WORD_W || IMM_W <= WSEL_W) begin : g_bad_src
         $error("wi_result_build: scalar and immediate must be wider than the fields used");
      end
   endgenerate

   wi_lane_merge #(.WORD_W(WORD_W), .LANES(NARROW_LANES)) u_narrow (
      .base_vec (dst_cur[NARROW_W-1:0]),
      .ins_word (ins_word),
      .lane_sel (imm[NSEL_W-1:0]),
      .merged   (narrow_res)
   );

   wi_lane_merge #(.WORD_W(WORD_W), .LANES(WIDE_LANES)) u_wide (
      .base_vec (wide_base),
      .ins_word (ins_word),
      .lane_sel (imm[WSEL_W-1:0]),
      .merged   (wide_res)
   );

   always_comb begin
      next_data = '0;
      if (!ud) begin
         unique case (form)
            FORM_NARROW:       next_data = {dst_cur[REG_W-1:NARROW_W], narrow_res};
            FORM_WIDE_INPLACE: next_data = {dst_cur[REG_W-1:WIDE_W], wide_res};
            FORM_WIDE_3OP:     next_data = {{(REG_W-WIDE_W){1'b0}}, wide_res};
            default:           next_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/word_insert_unit.sv
module word_insert_unit
   import wi_pkg::*;
#(
   parameter int REG_W        = 256,
   parameter int WORD_W       = 16,
   parameter int NARROW_LANES = 4,
   parameter int WIDE_LANES   = 8,
   parameter int IMM_W        = 8,
   parameter int SCALAR_W     = 32,
   localparam int NARROW_W = WORD_W * NARROW_LANES,
   localparam int WIDE_W   = WORD_W * WIDE_LANES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [1:0]          form,
   input  logic [IMM_W-1:0]    imm,
   input  logic [SCALAR_W-1:0] scalar_src,
   input  logic [REG_W-1:0]    dst_cur,
   input  logic [WIDE_W-1:0]   base_src,
   input  logic                len_bit,
   input  logic                w_bit,
   input  logic                long_mode,
   output logic                res_valid,
   output logic [REG_W-1:0]    res_data,
   output logic                wr_en,
   output logic                ud_exc
);
   generate
      if (NARROW_W >= WIDE_W || WIDE_W >= REG_W) begin : g_bad_widths
         $error("word_insert_unit: need narrow < wide < register width");
      end
   endgenerate

   wi_form_e         form_e;
   logic             ud;
   logic             accept;
   logic [REG_W-1:0] next_data;

   assign form_e = wi_form_e'(form);
   assign accept = req_valid & req_ready;

   wi_ud_check u_ud (
      .form      (form_e),
      .len_bit   (len_bit),
      .w_bit     (w_bit),
      .long_mode (long_mode),
      .ud        (ud)
   );

   wi_result_build #(
      .REG_W(REG_W), .WORD_W(WORD_W), .NARROW_LANES(NARROW_LANES),
      .WIDE_LANES(WIDE_LANES), .IMM_W(IMM_W), .SCALAR_W(SCALAR_W)
   ) u_build (
      .form       (form_e),
      .imm        (imm),
      .scalar_src (scalar_src),
      .dst_cur    (dst_cur),
      .base_src   (base_src),
      .ud         (ud),
      .next_data  (next_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_ready <= 1'b0;
         res_valid <= 1'b0;
         wr_en     <= 1'b0;
         ud_exc    <= 1'b0;
         res_data  <= '0;
      end else begin
         req_ready <= 1'b1;
         res_valid <= accept;
         wr_en     <= accept & ~ud;
         ud_exc    <= accept & ud;
         if (accept) res_data <= next_data;
      end
   end

   AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> res_valid); // R1
   AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !res_valid); // R1
   AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> res_valid); // R1
   AST_UD_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ud_exc |-> (res_valid && !wr_en)); // R11
   AST_UD_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ud_exc |-> (res_data == '0)); // R11
   AST_LENGTH_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && form == FORM_WIDE_3OP && len_bit) |=> ud_exc); // R9
   AST_3OP_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && wr_en && $past(form) == FORM_WIDE_3OP)
         |-> (res_data[REG_W-1:WIDE_W] == '0)); // R8
   AST_INPLACE_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && wr_en && $past(form) == FORM_WIDE_INPLACE)
         |-> (res_data[REG_W-1:WIDE_W] == $past(dst_cur[REG_W-1:WIDE_W]))); // R7
endmodule

// File: tb/word_insert_unit_bench.sv
module word_insert_unit_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [1:0]   form = '0;
   logic [7:0]   imm = '0;
   logic [31:0]  scalar_src = '0;
   logic [255:0] dst_cur = '0;
   logic [127:0] base_src = '0;
   logic         len_bit = 1'b0, w_bit = 1'b0, long_mode = 1'b0;
   logic         res_valid, wr_en, ud_exc;
   logic [255:0] res_data;
   int           checks = 0, errors = 0, cyc = 0;

   always #2 clk = ~clk;

   word_insert_unit u_word_insert_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .form(form), .imm(imm), .scalar_src(scalar_src), .dst_cur(dst_cur),
      .base_src(base_src), .len_bit(len_bit), .w_bit(w_bit), .long_mode(long_mode),
      .res_valid(res_valid), .res_data(res_data), .wr_en(wr_en), .ud_exc(ud_exc)
   );

   // fields: form[44:43] imm[42:35] scalar[34:3] len[2] w[1] long_mode[0]
   localparam logic [44:0] VEC [12] = '{
      {2'b00, 8'h00, 32'hDEAD_1234, 3'b000},
      {2'b00, 8'hFE, 32'h5555_ABCD, 3'b000},
      {2'b00, 8'h07, 32'h0000_7E57, 3'b110},
      {2'b01, 8'h05, 32'hFFFF_0F0F, 3'b000},
      {2'b01, 8'hF8, 32'h1234_C0DE, 3'b001},
      {2'b01, 8'h0F, 32'hAAAA_BEEF, 3'b110},
      {2'b10, 8'h03, 32'h8765_4321, 3'b000},
      {2'b10, 8'hFE, 32'h0F0F_F00D, 3'b001},
      {2'b10, 8'h01, 32'h1111_2222, 3'b101},
      {2'b10, 8'h02, 32'h3333_4444, 3'b010},
      {2'b10, 8'h04, 32'h5555_6666, 3'b011},
      {2'b11, 8'h00, 32'h7777_8888, 3'b000}
   };

   function automatic string tag_of(int i);
      case (i)
         0, 1, 2: return "R3 R5 R6 R2";
         3:       return "R7 R4 R5";
         4:       return "R4 R7";
         5:       return "R10 R7";
         6:       return "R8 R6 R5";
         7:       return "R4 R8";
         8:       return "R9";
         9:       return "R10";
         10:      return "R10 R8";
         default: return "R11";
      endcase
   endfunction

   function automatic logic [255:0] dst_pat(int i);
      return {4{64'hD0D1_D2D3_D4D5_D6D7 ^ {8{i[7:0]}}}} ^ {128'h0F, 128'hF0};
   endfunction

   function automatic logic [127:0] base_pat(int i);
      return {2{64'hB0B1_B2B3_B4B5_B6B7 ^ {8{i[7:0] + 8'h3C}}}};
   endfunction

   function automatic logic model_ud(logic [1:0] f, logic l, logic w, logic lm);
      if (f == 2'b11) return 1'b1;
      if (f == 2'b10) return l || (w && !lm);
      return 1'b0;
   endfunction

   function automatic logic [255:0] model_data(logic [1:0] f, logic [7:0] im,
         logic [31:0] s, logic [255:0] d, logic [127:0] b, logic u);
      logic [127:0] mask, v, ins;
      int sh;
      if (u) return '0;
      if (f == 2'b00) begin
         sh   = int'(im & 8'h03) * 16;
         mask = {64'h0, 64'hFFFF << sh};
         ins  = {64'h0, {48'h0, s[15:0]} << sh} & mask;
         v    = ({64'h0, d[63:0]} & ~mask) | ins;
         return {d[255:64], v[63:0]};
      end
      sh   = int'(im & 8'h07) * 16;
      mask = 128'hFFFF << sh;
      ins  = ({112'h0, s[15:0]} << sh) & mask;
      if (f == 2'b01) return {d[255:128], (d[127:0] & ~mask) | ins};
      return {128'h0, (b & ~mask) | ins};
   endfunction

   task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(logic [1:0] f, logic [7:0] im, logic [31:0] s,
         logic [255:0] d, logic [127:0] b, logic l, logic w, logic lm);
      form = f; imm = im; scalar_src = s; dst_cur = d; base_src = b;
      len_bit = l; w_bit = w; long_mode = lm; req_valid = 1'b1;
   endtask

   task automatic expect_result(string tag, logic [1:0] f, logic [7:0] im,
         logic [31:0] s, logic [255:0] d, logic [127:0] b, logic l, logic w, logic lm);
      logic u;
      u = model_ud(f, l, w, lm);
      check({tag, " valid"}, 256'(res_valid), 256'(1'b1));
      check({tag, " ud"},    256'(ud_exc),    256'(u));
      check({tag, " wr"},    256'(wr_en),     256'(!u));
      check({tag, " data"},  res_data,        model_data(f, im, s, d, b, u));
   endtask

   task automatic run_one(string tag, logic [1:0] f, logic [7:0] im, logic [31:0] s,
         logic [255:0] d, logic [127:0] b, logic l, logic w, logic lm);
      @(negedge clk);
      drive(f, im, s, d, b, l, w, lm);
      @(negedge clk);
      req_valid = 1'b0;
      expect_result(tag, f, im, s, d, b, l, w, lm);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++; errors++;
         $display("FAIL R1 watchdog actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      // R1: reset state
      #1;
      check("R1 reset ready", 256'(req_ready), 256'(1'b0));
      check("R1 reset valid", 256'(res_valid), 256'(1'b0));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", 256'(req_ready), 256'(1'b1));
      check("R1 idle valid", 256'(res_valid), 256'(1'b0));
      check("R1 idle wr_en", 256'(wr_en), 256'(1'b0));
      check("R1 idle ud", 256'(ud_exc), 256'(1'b0));

      for (int i = 0; i < 12; i++) begin
         run_one(tag_of(i), VEC[i][44:43], VEC[i][42:35], VEC[i][34:3],
                 dst_pat(i), base_pat(i), VEC[i][2], VEC[i][1], VEC[i][0]);
      end

      // R1: result lasts a single cycle
      @(negedge clk);
      check("R1 single-cycle valid", 256'(res_valid), 256'(1'b0));

      // R2: upper scalar bits do not reach the result
      run_one("R2 hi ones", 2'b01, 8'h02, 32'hFFFF_1357, dst_pat(20), base_pat(20), 0, 0, 0);
      run_one("R2 hi zeros", 2'b01, 8'h02, 32'h0000_1357, dst_pat(20), base_pat(20), 0, 0, 0);

      // R1: back-to-back requests, one result per accepted cycle
      @(negedge clk);
      drive(2'b00, 8'h01, 32'h0000_AAAA, dst_pat(30), base_pat(30), 0, 0, 0);
      @(negedge clk);
      expect_result("R1 b2b first", 2'b00, 8'h01, 32'h0000_AAAA, dst_pat(30), base_pat(30), 0, 0, 0);
      drive(2'b10, 8'h07, 32'h0000_BBBB, dst_pat(31), base_pat(31), 0, 0, 0);
      @(negedge clk);
      req_valid = 1'b0;
      expect_result("R1 b2b second", 2'b10, 8'h07, 32'h0000_BBBB, dst_pat(31), base_pat(31), 0, 0, 0);
      @(negedge clk);
      check("R1 b2b drop", 256'(res_valid), 256'(1'b0));
      check("R11 exception drop", 256'(ud_exc), 256'(1'b0));

      finish_run();
   end
endmodule